// File: doc/BRIEF.md
# Configuration Shadow Register Bank with Reboot Sequencer

This block keeps the live copy of a supervisor's configuration: a small bank of byte-wide registers that the serial slave reads and writes directly. A separate nonvolatile image of the same size sits behind a simple memory port. When reset is released, the block first forces factory defaults and then copies the whole image into the live bank. It performs the same copy whenever the serial slave passes on the reboot command byte. Writes aimed at the image's address window are forwarded to the memory as single strobes.

While a copy, the startup hold that follows it, or a nonvolatile write is in progress, `busy` is high. During that time the block drops register writes and commands, so the serial slave can refuse the bus traffic. The copy is sequential. It issues one memory read per entry in ascending order, so the live bank changes one entry at a time. The startup hold after the copy is a parameter counted in clock cycles.

Top module: `cfg_shadow_ctl`

## Requirements
- R1: While reset is asserted, every live entry reads 00h, except entries 11h to 15h (indices DEF_LO..DEF_HI), which read 01h.
- R2: After reset is released, the block reloads the image on its own, and every live entry i then equals the image byte at memory address NV_BASE+i (80h+i).
- R3: A reload issues exactly one single-cycle read strobe per entry, in ascending order. `busy` stays high for exactly 2*NREG+DELAY_CYC clock cycles, counted from the edge that accepts the command or from the release of reset.
- R4: A command with byte C4h, accepted while `busy` is low, starts a reload on the next clock. Any other command byte leaves `busy` low and the bank unchanged.
- R5: While `busy` is low, a write to an address below NREG updates that entry, and reads return the entry combinationally. Addresses from NREG up to NV_BASE-1 read as 00h and ignore writes.
- R6: While `busy` is low, a write to an address in NV_BASE..NV_BASE+NREG-1 drives a one-cycle `nv_we` with that address and data, and leaves the live bank untouched. `busy` is high from the next cycle until the cycle after `nv_wdone`.
- R7: While `busy` is high, register writes and commands are dropped, and the bank changes only through reload data.
- R8: A read during a reload returns the current bank contents, so entries not yet reloaded still hold their earlier values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Register address from the serial slave |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte value |
| nv_re | output | 1 | Image read strobe |
| nv_we | output | 1 | Image write strobe |
| nv_addr | output | AW | Image address, valid with either strobe |
| nv_wdata | output | DW | Image write data, valid with `nv_we` |
| nv_rdata | input | DW | Image read data, valid with `nv_rvalid` |
| nv_rvalid | input | 1 | Read data valid, one pulse per read strobe |
| nv_wdone | input | 1 | Image write finished |
| busy | output | 1 | Reload, startup hold or image write in progress |

## Verification
The assertions assume that the memory raises `nv_rvalid` only after a read strobe and `nv_wdone` only after a write strobe, each once. They also assume that the serial slave changes `reg_addr` only when it means to read a different entry. The bench's memory model answers every read one clock after the strobe and signals write completion after a fixed latency. It never produces an unsolicited pulse. The stimulus drives inputs at the falling edge only, so each request meets a well-defined block state at the next rising edge.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_LD_REQ  = 3'd1,
      ST_LD_WAIT = 3'd2,
      ST_HOLD    = 3'd3,
      ST_NV_WAIT = 3'd4
   } cfgsh_state_e;
endpackage

// File: rtl/cfgsh_bank.sv
module cfgsh_bank #(
   parameter int DW     = 8,
   parameter int NREG   = 24,
   parameter int DEF_LO = 17,
   parameter int DEF_HI = 21,
   localparam int IW    = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic          ld_en,
   input  logic [IW-1:0] ld_idx,
   input  logic [DW-1:0] ld_data,
   input  logic          rd_hit,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] ent [NREG];

   // one register per entry, each with its own factory default
   for (genvar g = 0; g < NREG; g++) begin : g_ent
      localparam logic [DW-1:0] FACT = (g >= DEF_LO && g <= DEF_HI) ? DW'(1) : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[g] <= FACT;
         else if (ld_en && ld_idx == IW'(g))
            ent[g] <= ld_data;
         else if (wr_en && wr_idx == IW'(g))
            ent[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_hit) rd_data = ent[rd_idx];
   end

   AST_LD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> (int'(ld_idx) < NREG));                        // R3
   AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, ld_en}));                               // R7
endmodule

// File: rtl/cfgsh_seq.sv
module cfgsh_seq
   import cfgsh_pkg::*;
#(
   parameter int          AW         = 8,
   parameter int          DW         = 8,
   parameter int          NREG       = 24,
   parameter int          NV_BASE    = 128,
   parameter int          DELAY_CYC  = 250000,
   parameter logic [7:0]  REBOOT_CMD = 8'hC4,
   localparam int         IW         = $clog2(NREG),
   localparam int         CW         = $clog2(DELAY_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [7:0]    cmd_byte,
   input  logic          nvwr_req,
   input  logic          nv_rvalid,
   input  logic [DW-1:0] nv_rdata,
   input  logic          nv_wdone,
   output logic          busy,
   output logic          nv_re,
   output logic          nv_we,
   output logic [AW-1:0] ld_addr,
   output logic          ld_en,
   output logic [IW-1:0] ld_idx,
   output logic [DW-1:0] ld_data
);
   cfgsh_state_e  st;
   logic [IW-1:0] idx;
   logic [CW-1:0] cnt;
   logic          go;

   assign go      = cmd_valid && (cmd_byte == REBOOT_CMD);
   assign busy    = (st != ST_IDLE);
   assign nv_re   = (st == ST_LD_REQ);
   assign nv_we   = (st == ST_IDLE) && !go && nvwr_req;
   assign ld_en   = (st == ST_LD_WAIT) && nv_rvalid;
   assign ld_idx  = idx;
   assign ld_data = nv_rdata;
   assign ld_addr = AW'(NV_BASE) + AW'(idx);

   // reset lands in the reload path: power-up equals reboot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_LD_REQ;
         idx <= '0;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (go) begin
                  st  <= ST_LD_REQ;
                  idx <= '0;
               end else if (nvwr_req) begin
                  st <= ST_NV_WAIT;
               end
            end
            ST_LD_REQ: st <= ST_LD_WAIT;
            ST_LD_WAIT: begin
               if (nv_rvalid) begin
                  if (idx == IW'(NREG - 1)) begin
                     st  <= ST_HOLD;
                     cnt <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= ST_LD_REQ;
                  end
               end
            end
            ST_HOLD: begin
               if (cnt == CW'(DELAY_CYC - 1)) st <= ST_IDLE;
               else                           cnt <= cnt + 1'b1;
            end
            ST_NV_WAIT: if (nv_wdone) st <= ST_IDLE;
            default:    st <= ST_IDLE;
         endcase
      end
   end

   AST_CMD_STARTS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go) |=> (busy && nv_re));                      // R4
   AST_OTHER_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && !go && !nvwr_req) |=> !busy);     // R4
   AST_RE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      nv_re |=> !nv_re);                                       // R3
   AST_NVWE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      nv_we |=> (busy && !nv_re));                             // R6
   AST_WDONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_NV_WAIT && nv_wdone) |=> !busy);               // R6
endmodule

// File: rtl/cfg_shadow_ctl.sv
module cfg_shadow_ctl #(
   parameter int         AW         = 8,
   parameter int         DW         = 8,
   parameter int         NREG       = 24,
   parameter int         NV_BASE    = 128,
   parameter int         DEF_LO     = 17,
   parameter int         DEF_HI     = 21,
   parameter int         DELAY_CYC  = 250000,
   parameter logic [7:0] REBOOT_CMD = 8'hC4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_we,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          cmd_valid,
   input  logic [7:0]    cmd_byte,
   output logic          nv_re,
   output logic          nv_we,
   output logic [AW-1:0] nv_addr,
   output logic [DW-1:0] nv_wdata,
   input  logic [DW-1:0] nv_rdata,
   input  logic          nv_rvalid,
   input  logic          nv_wdone,
   output logic          busy
);
   localparam int          IW    = $clog2(NREG);
   localparam logic [AW:0] VOL_HI = (AW+1)'(NREG);
   localparam logic [AW:0] NV_LO  = (AW+1)'(NV_BASE);
   localparam logic [AW:0] NV_HI  = (AW+1)'(NV_BASE + NREG);

   if (NREG < 2 || IW > AW) begin : g_bad_size
      $error("cfg_shadow_ctl: NREG must be >= 2 and addressable in AW bits");
   end
   if (NV_BASE < NREG || NV_BASE + NREG > (1 << AW)) begin : g_bad_base
      $error("cfg_shadow_ctl: image window overlaps bank or exceeds address space");
   end
   if (DELAY_CYC < 1) begin : g_bad_delay
      $error("cfg_shadow_ctl: DELAY_CYC must be at least 1");
   end
   if (DEF_LO > DEF_HI || DEF_HI >= NREG) begin : g_bad_def
      $error("cfg_shadow_ctl: default-set range outside the bank");
   end

   logic          vol_hit, nv_hit, vol_wr, ld_en;
   logic [IW-1:0] ld_idx;
   logic [DW-1:0] ld_data;
   logic [AW-1:0] ld_addr;

   assign vol_hit  = ({1'b0, reg_addr} < VOL_HI);
   assign nv_hit   = ({1'b0, reg_addr} >= NV_LO) && ({1'b0, reg_addr} < NV_HI);
   assign vol_wr   = reg_we && vol_hit && !busy;
   assign nv_addr  = busy ? ld_addr : reg_addr;
   assign nv_wdata = reg_wdata;

   cfgsh_seq #(
      .AW(AW), .DW(DW), .NREG(NREG), .NV_BASE(NV_BASE),
      .DELAY_CYC(DELAY_CYC), .REBOOT_CMD(REBOOT_CMD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .nvwr_req(reg_we && nv_hit),
      .nv_rvalid(nv_rvalid), .nv_rdata(nv_rdata), .nv_wdone(nv_wdone),
      .busy(busy), .nv_re(nv_re), .nv_we(nv_we), .ld_addr(ld_addr),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data)
   );

   cfgsh_bank #(
      .DW(DW), .NREG(NREG), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(vol_wr), .wr_idx(reg_addr[IW-1:0]), .wr_data(reg_wdata),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .rd_hit(vol_hit), .rd_idx(reg_addr[IW-1:0]), .rd_data(reg_rdata)
   );

   AST_BUSY_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !nv_rvalid) |=>
         ((reg_rdata == $past(reg_rdata)) || (reg_addr != $past(reg_addr)))); // R7
   AST_NV_WR_SPARES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_we && !nv_rvalid) |=>
         ((reg_rdata == $past(reg_rdata)) || (reg_addr != $past(reg_addr)))); // R6
endmodule

// File: tb/tb_cfg_shadow_ctl.sv
`timescale 1ns/1ps
module tb_cfg_shadow_ctl;
   localparam int NREG = 24;
   localparam int DLY  = 20;
   localparam int WLAT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [7:0] reg_addr = '0, reg_wdata = '0, cmd_byte = '0;
   logic       reg_we = 1'b0, cmd_valid = 1'b0;
   logic [7:0] reg_rdata, nv_addr, nv_wdata;
   logic [7:0] nv_rdata = '0;
   logic       nv_re, nv_we, busy;
   logic       nv_rvalid = 1'b0, nv_wdone = 1'b0;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cfg_shadow_ctl #(.NREG(NREG), .DELAY_CYC(DLY)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
      .cmd_byte(cmd_byte), .nv_re(nv_re), .nv_we(nv_we), .nv_addr(nv_addr),
      .nv_wdata(nv_wdata), .nv_rdata(nv_rdata), .nv_rvalid(nv_rvalid),
      .nv_wdone(nv_wdone), .busy(busy)
   );

   function automatic logic [7:0] img(input int i);
      return 8'hA0 ^ 8'(i * 7);
   endfunction
   function automatic logic [7:0] vpat(input int i);
      return 8'(i * 13 + 5);
   endfunction

   // behavioural image memory
   logic [7:0] nvm [NREG];
   logic [7:0] waddr, wdat, roff, woff;
   int         wcnt;
   assign roff = nv_addr - 8'h80;
   assign woff = waddr - 8'h80;
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) nvm[i] <= img(i);
         nv_rvalid <= 1'b0;
         nv_wdone  <= 1'b0;
         wcnt      <= 0;
      end else begin
         nv_rvalid <= nv_re;
         if (nv_re) nv_rdata <= nvm[roff[4:0]];
         nv_wdone <= 1'b0;
         if (nv_we) begin
            wcnt  <= WLAT;
            waddr <= nv_addr;
            wdat  <= nv_wdata;
         end else if (wcnt != 0) begin
            wcnt <= wcnt - 1;
            if (wcnt == 1) begin
               nvm[woff[4:0]] <= wdat;
               nv_wdone <= 1'b1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
      reg_addr = a;
      #1;
      chk(reg_rdata == e, req, reg_rdata, e);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_byte = b;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (busy && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      #1 rst_n = 1'b0;
      #20;
      // R1: factory defaults visible during reset
      for (int i = 0; i < NREG; i++)
         rd_chk(8'(i), (i >= 17 && i <= 21) ? 8'h01 : 8'h00, "R1 default");
      chk(busy == 1'b1, "R3 busy in reset", busy, 1);

      // R2/R3: automatic reload after reset release
      @(negedge clk);
      rst_n = 1'b1;
      busy_len(n);
      chk(n == 2 * NREG + DLY, "R3 power-up busy length", n, 2 * NREG + DLY);
      for (int i = 0; i < NREG; i++) rd_chk(8'(i), img(i), "R2 reload");

      // R5: volatile writes and read-back
      for (int i = 0; i < NREG; i++) wr(8'(i), vpat(i));
      for (int i = 0; i < NREG; i++) rd_chk(8'(i), vpat(i), "R5 write/read");
      // R5: gap addresses read zero and ignore writes
      for (int a = NREG; a < 8'h80; a++) wr(8'(a), 8'hFF);
      for (int a = NREG; a < 8'h80; a++) rd_chk(8'(a), 8'h00, "R5 gap reads 0");
      for (int i = 0; i < NREG; i++) rd_chk(8'(i), vpat(i), "R5 gap write ignored");

      // R4: every command byte but C4h leaves the block idle
      for (int b = 0; b < 256; b++) begin
         if (b != 8'hC4) begin
            cmd(8'(b));
            chk(busy == 1'b0, "R4 other byte ignored", busy, 0);
         end
      end
      rd_chk(8'd7, vpat(7), "R4 bank unchanged");

      // R6: image write strobe, busy until done
      @(negedge clk);
      reg_addr = 8'h83; reg_wdata = 8'h5A; reg_we = 1'b1;
      #1;
      chk(nv_we == 1'b1, "R6 nv_we strobe", nv_we, 1);
      chk(nv_addr == 8'h83, "R6 nv_addr", nv_addr, 8'h83);
      chk(nv_wdata == 8'h5A, "R6 nv_wdata", nv_wdata, 8'h5A);
      @(negedge clk);
      reg_we = 1'b0;
      chk(busy == 1'b1, "R6 busy after strobe", busy, 1);
      chk(nv_we == 1'b0, "R6 strobe single cycle", nv_we, 0);
      // R7: write and reboot attempts while busy
      reg_addr = 8'h00; reg_wdata = 8'hEE; reg_we = 1'b1;
      cmd_valid = 1'b1; cmd_byte = 8'hC4;
      @(negedge clk);
      reg_we = 1'b0; cmd_valid = 1'b0;
      n = 0;
      while (busy && n < 50) begin n++; @(negedge clk); end
      chk(!busy, "R6 busy clears after done", busy, 0);
      @(negedge clk);
      chk(!busy, "R7 reboot during busy dropped", busy, 0);
      rd_chk(8'h00, vpat(0), "R7 write during busy dropped");
      rd_chk(8'h03, vpat(3), "R6 bank untouched by image write");

      // R4/R3/R8: software reboot
      cmd(8'hC4);
      n = 0;
      while (busy && n < 100000) begin
         n++;
         if (n == 11) begin
            rd_chk(8'd0, img(0), "R8 early entry reloaded");
            rd_chk(8'd23, vpat(23), "R8 late entry keeps old value");
         end
         @(negedge clk);
      end
      chk(n == 2 * NREG + DLY, "R3 reboot busy length", n, 2 * NREG + DLY);
      for (int i = 0; i < NREG; i++)
         rd_chk(8'(i), (i == 3) ? 8'h5A : img(i), "R4 reboot reload");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule